// File: doc/BRIEF.md
# Deep Sleep Wake Source Logger

This block sits in an always-on power domain and watches six wake-up request lines while the rest of the chip is in deep sleep. When the first request arrives, it records which line fired in a wake status word. It then drives a reset request for a fixed number of cycles, so that the core goes through a full power-on-style restart and resumes from its reset vector. A sticky exit flag stays set across that restart, so that boot code can tell a deep-sleep exit apart from a cold start. Only software clears the flag.

Entry is a two-step handshake. A sleep request moves the block out of the run state into an entry phase, and the power controller's "fully asleep" indication completes the entry. The wake status word is cleared at that moment. Any request line that is active during the entry phase cancels the entry with a one-cycle abort pulse and is not logged. Once a wake is logged, later requests leave the status word alone until the next entry. Software reads the status word as a low byte and a high byte through a small read port. It clears the exit flag with a write.

Top module: `dsleep_wake_logger`

## Requirements
- R1: Wake line i (0 = master-clear pin, 1 = power-on event, 2 = clock alarm, 3 = external interrupt pin 0, 4 = deep-sleep watchdog timeout, 5 = ultra-low-power wake input) maps to status bit i for i = 0..4 and to status bit 8 for i = 5. All other status bits always read 0.
- R2: A wake line that goes high while the block is in deep sleep raises `core_rst_o` at the third rising edge after the change. The two-flop synchroniser accounts for two of those edges. `core_rst_o` then stays high for exactly RST_CYCLES cycles (default 16), after which the block returns to the run state.
- R3: Wake lines are sampled only after the entry has completed, meaning `asleep_i` was seen during the entry phase. An event before that point is never written to the status word.
- R4: `exit_flag_o` is set when a wake is logged. A write with `sw_addr_i` = 2 and `sw_wdata_i` = 1 clears it, and nothing else does. If a wake and a clear happen in the same cycle, the flag ends up set.
- R5: If a synchronised wake line is high during the entry phase, `abort_o` pulses for one cycle and the block returns to the run state. In that case there is no reset request and the status word is left unchanged.
- R6: Only the first wake event after an entry is logged. Lines that assert later, including during the reset request or in the run state, leave the status word unchanged until the next entry.
- R7: When several lines become high in the same cycle, all of their bits are recorded.
- R8: The status word reads 0 in the cycle after an entry completes.
- R9: The read port is combinational. Address 0 returns status bits 7:0, address 1 returns bits 15:8, address 2 returns the exit flag in bit 0, and address 3 returns 0.
- R10: `sleep_req_i` has no effect unless the block is in the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Request to begin deep-sleep entry |
| asleep_i | input | 1 | Power controller reports domain fully asleep |
| wake_src_i | input | 6 | Asynchronous wake request lines |
| sw_wr_i | input | 1 | Software write strobe |
| sw_addr_i | input | 2 | Software register address |
| sw_wdata_i | input | 1 | Write data bit 0 (1 clears the exit flag at address 2) |
| rd_data_o | output | 8 | Read data for `sw_addr_i` |
| status_o | output | 16 | Wake status word |
| exit_flag_o | output | 1 | Sticky deep-sleep exit flag |
| abort_o | output | 1 | One-cycle pulse: entry cancelled |
| core_rst_o | output | 1 | Reset request to the core |

## Verification
A change on a wake line shows up on `status_o`, `exit_flag_o` and `core_rst_o`, or on `abort_o`, at the third rising edge after the change. A software flag clear and a sleep request take effect at the next edge, and read data follows the address with no edge at all. The reference model in the bench delays the wake lines through a two-deep queue and applies every register update at the same edge the design does. It compares all outputs 2 ns after each rising edge. The directed checks drive inputs just after a falling edge and count whole cycles to the falling edge at which each result is due.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

  localparam int NUM_SRC   = 6;
  localparam int LOW_SRCS  = 5;
  localparam int HIGH_BASE = 8;
  localparam int STAT_W    = 16;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_ENTERING = 2'd1,
    ST_DEEP     = 2'd2,
    ST_WAKE_RST = 2'd3
  } dsw_state_e;

  // Bit position in the status word for wake line i
  function automatic int src_pos(input int i);
    return (i < LOW_SRCS) ? i : HIGH_BASE + (i - LOW_SRCS);
  endfunction

  // Spread synchronised wake lines onto the status word layout
  function automatic logic [STAT_W-1:0] src_to_status(input logic [NUM_SRC-1:0] s);
    logic [STAT_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_SRC; i++) r[src_pos(i)] = s[i];
    return r;
  endfunction

  localparam logic [STAT_W-1:0] USED_MASK = src_to_status('1);

endpackage

// File: rtl/dsw_sync.sv
module dsw_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end

endmodule

// File: rtl/dsw_ctrl.sv
module dsw_ctrl
  import dsw_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req_i,
  input  logic asleep_i,
  input  logic any_wake_i,
  output logic enter_evt_o,
  output logic wake_evt_o,
  output logic abort_evt_o,
  output logic core_rst_o,
  output logic abort_o
);

  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  dsw_state_e st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          abort_q;

  always_comb begin
    st_d        = st_q;
    enter_evt_o = 1'b0;
    wake_evt_o  = 1'b0;
    abort_evt_o = 1'b0;
    case (st_q)
      ST_RUN:      if (sleep_req_i) st_d = ST_ENTERING;
      ST_ENTERING: begin
        if (any_wake_i) begin
          abort_evt_o = 1'b1;
          st_d        = ST_RUN;
        end else if (asleep_i) begin
          enter_evt_o = 1'b1;
          st_d        = ST_DEEP;
        end
      end
      ST_DEEP: begin
        if (any_wake_i) begin
          wake_evt_o = 1'b1;
          st_d       = ST_WAKE_RST;
        end
      end
      ST_WAKE_RST: if (cnt_q == LAST) st_d = ST_RUN;
      default:     st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      cnt_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      abort_q <= abort_evt_o;
      if (wake_evt_o)                cnt_q <= '0;
      else if (st_q == ST_WAKE_RST)  cnt_q <= cnt_q + CW'(1);
    end
  end

  assign core_rst_o = (st_q == ST_WAKE_RST);
  assign abort_o    = abort_q;

endmodule

// File: rtl/dsw_status.sv
module dsw_status
  import dsw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               capture_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               flag_clr_i,
  output logic [STAT_W-1:0]  status_o,
  output logic               flag_o
);

  logic [STAT_W-1:0] status_q;
  logic              flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (clear_i)        status_q <= '0;
      else if (capture_i) status_q <= src_to_status(src_i);
      if (capture_i)       flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign flag_o   = flag_q;

endmodule

// File: rtl/dsleep_wake_logger.sv
module dsleep_wake_logger
  import dsw_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req_i,
  input  logic               asleep_i,
  input  logic [NUM_SRC-1:0] wake_src_i,
  input  logic               sw_wr_i,
  input  logic [1:0]         sw_addr_i,
  input  logic               sw_wdata_i,
  output logic [7:0]         rd_data_o,
  output logic [STAT_W-1:0]  status_o,
  output logic               exit_flag_o,
  output logic               abort_o,
  output logic               core_rst_o
);

  logic [NUM_SRC-1:0] wake_sync;
  logic               any_wake;
  logic               enter_evt, wake_evt, abort_evt, flag_clr;

  dsw_sync #(.W(NUM_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (wake_src_i),
    .q_o   (wake_sync)
  );

  assign any_wake = |wake_sync;
  assign flag_clr = sw_wr_i && (sw_addr_i == ADDR_FLAG) && sw_wdata_i;

  dsw_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req_i (sleep_req_i),
    .asleep_i    (asleep_i),
    .any_wake_i  (any_wake),
    .enter_evt_o (enter_evt),
    .wake_evt_o  (wake_evt),
    .abort_evt_o (abort_evt),
    .core_rst_o  (core_rst_o),
    .abort_o     (abort_o)
  );

  dsw_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (enter_evt),
    .capture_i  (wake_evt),
    .src_i      (wake_sync),
    .flag_clr_i (flag_clr),
    .status_o   (status_o),
    .flag_o     (exit_flag_o)
  );

  always_comb begin
    case (sw_addr_i)
      ADDR_LO:   rd_data_o = status_o[7:0];
      ADDR_HI:   rd_data_o = status_o[15:8];
      ADDR_FLAG: rd_data_o = {7'd0, exit_flag_o};
      default:   rd_data_o = 8'd0;
    endcase
  end

endmodule

// File: rtl/dsw_checker.sv
module dsw_checker
  import dsw_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STAT_W-1:0] status_o,
  input logic              exit_flag_o,
  input logic              abort_o,
  input logic              core_rst_o,
  input logic              enter_evt,
  input logic              wake_evt,
  input logic              abort_evt,
  input logic              flag_clr
);

  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_cnt <= '0;
    else if (core_rst_o) hi_cnt <= hi_cnt + CW'(1);
    else                 hi_cnt <= '0;
  end

  // R1
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~USED_MASK) == '0);

  // R2
  rst_follows_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> core_rst_o);

  // R2
  rst_not_too_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> (hi_cnt < CW'(RST_CYCLES)));

  // R2
  rst_full_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_o) |-> (hi_cnt == CW'(RST_CYCLES)));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_flag_o && !flag_clr |=> exit_flag_o);

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> exit_flag_o);

  // R5
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  // R5
  abort_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (abort_o && !core_rst_o && $stable(status_o)));

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enter_evt && !wake_evt |=> $stable(status_o));

  // R3
  wake_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (status_o != '0));

  // R8
  clear_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> (status_o == '0));

endmodule

bind dsleep_wake_logger dsw_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_o    (status_o),
  .exit_flag_o (exit_flag_o),
  .abort_o     (abort_o),
  .core_rst_o  (core_rst_o),
  .enter_evt   (enter_evt),
  .wake_evt    (wake_evt),
  .abort_evt   (abort_evt),
  .flag_clr    (flag_clr)
);

// File: tb/dsleep_wake_logger_tb.sv
`timescale 1ns/1ps
module dsleep_wake_logger_tb;

  localparam int RST = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_req = 1'b0;
  logic        asleep = 1'b0;
  logic [5:0]  wake = '0;
  logic        sw_wr = 1'b0;
  logic [1:0]  sw_addr = 2'd0;
  logic        sw_wdata = 1'b0;
  logic [7:0]  rd_data;
  logic [15:0] status;
  logic        flag, abort_p, core_rst;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dsleep_wake_logger #(.RST_CYCLES(RST)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req), .asleep_i(asleep),
    .wake_src_i(wake), .sw_wr_i(sw_wr), .sw_addr_i(sw_addr), .sw_wdata_i(sw_wdata),
    .rd_data_o(rd_data), .status_o(status), .exit_flag_o(flag),
    .abort_o(abort_p), .core_rst_o(core_rst)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_state = 0;  // 0 run, 1 entering, 2 asleep, 3 reset request
  int          m_cnt = 0;
  logic [15:0] m_status = '0;
  bit          m_flag = 0, m_abort = 0;
  logic [5:0]  hist[$] = '{6'd0, 6'd0};

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_status = '0; m_flag = 0; m_abort = 0;
      hist = '{6'd0, 6'd0};
    end else begin
      logic [5:0] seen;
      bit set_now;
      bit clr;
      seen = hist.pop_front();
      hist.push_back(wake);
      clr = sw_wr && (sw_addr == 2'd2) && sw_wdata;
      set_now = 0;
      m_abort = 0;
      case (m_state)
        0: if (sleep_req) m_state = 1;
        1: if (seen != 0) begin m_abort = 1; m_state = 0; end
           else if (asleep) begin m_state = 2; m_status = '0; end
        2: if (seen != 0) begin
             m_status = '0;
             for (int i = 0; i < 6; i++)
               if (seen[i]) m_status[(i == 5) ? 8 : i] = 1'b1;
             m_state = 3; m_cnt = 0; set_now = 1;
           end
        default: begin m_cnt++; if (m_cnt == RST) m_state = 0; end
      endcase
      if (set_now) m_flag = 1;
      else if (clr) m_flag = 0;
    end
    #2;
    if (!done) begin
      logic [7:0] m_rd;
      case (sw_addr)
        2'd0: m_rd = m_status[7:0];
        2'd1: m_rd = m_status[15:8];
        2'd2: m_rd = {7'd0, m_flag};
        default: m_rd = 8'd0;
      endcase
      chk("R1", "model status", status, m_status);
      chk("R4", "model flag", {15'd0, flag}, {15'd0, m_flag});
      chk("R5", "model abort", {15'd0, abort_p}, {15'd0, m_abort});
      chk("R2", "model reset req", {15'd0, core_rst}, {15'd0, 1'(m_state == 3)});
      chk("R9", "model read", {8'd0, rd_data}, {8'd0, m_rd});
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_sleep();
    sleep_req = 1'b1; asleep = 1'b1;
    step(1);
    sleep_req = 1'b0;
    step(1);  // entry completes at this edge
  endtask

  task automatic summary();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    total++; bad++;
    $display("FAIL R2 watchdog: actual=timeout expected=finished");
    summary();
  end

  initial begin
    step(3);
    chk("R1", "reset status", status, 16'h0000);
    chk("R4", "reset flag", {15'd0, flag}, 16'h0);
    chk("R2", "reset req", {15'd0, core_rst}, 16'h0);
    rst_n = 1'b1;
    step(2);

    // R5 / R3: event during entry aborts, nothing logged
    sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    wake = 6'b000100;
    step(3);
    chk("R5", "abort pulse", {15'd0, abort_p}, 16'h1);
    chk("R3", "pre-entry event unlogged", status, 16'h0000);
    chk("R5", "no reset on abort", {15'd0, core_rst}, 16'h0);
    step(1);
    chk("R5", "abort one cycle", {15'd0, abort_p}, 16'h0);
    wake = '0; step(4);

    // R2 / R1 / R4: wake from alarm line
    enter_sleep();
    chk("R8", "cleared at entry", status, 16'h0000);
    wake = 6'b000100;
    step(2);
    chk("R2", "reset not yet", {15'd0, core_rst}, 16'h0);
    step(1);
    chk("R2", "reset raised", {15'd0, core_rst}, 16'h1);
    chk("R1", "alarm bit", status, 16'h0004);
    chk("R4", "flag set", {15'd0, flag}, 16'h1);
    asleep = 1'b0;
    wake = 6'b010100;  // watchdog line later: ignored
    step(RST - 1);
    chk("R2", "reset still high", {15'd0, core_rst}, 16'h1);
    step(1);
    chk("R2", "reset released", {15'd0, core_rst}, 16'h0);
    chk("R6", "later line ignored", status, 16'h0004);

    // R9 read port
    sw_addr = 2'd0; #1 chk("R9", "read low", {8'd0, rd_data}, 16'h0004);
    sw_addr = 2'd1; #1 chk("R9", "read high", {8'd0, rd_data}, 16'h0000);
    sw_addr = 2'd2; #1 chk("R9", "read flag", {8'd0, rd_data}, 16'h0001);
    sw_addr = 2'd3; #1 chk("R9", "read spare", {8'd0, rd_data}, 16'h0000);
    step(1);

    // R4: write of 0 keeps flag, write of 1 clears it
    sw_wr = 1'b1; sw_addr = 2'd2; sw_wdata = 1'b0; step(1);
    chk("R4", "zero write keeps flag", {15'd0, flag}, 16'h1);
    sw_wdata = 1'b1; step(1);
    sw_wr = 1'b0; sw_wdata = 1'b0;
    chk("R4", "flag cleared", {15'd0, flag}, 16'h0);
    wake = '0; step(4);

    // R8 / R10 / R7
    enter_sleep();
    chk("R8", "status cleared on entry", status, 16'h0000);
    sleep_req = 1'b1; step(1); sleep_req = 1'b0; step(3);
    chk("R10", "sleep req ignored while asleep", {15'd0, abort_p | core_rst}, 16'h0);
    wake = 6'b100001;
    step(3);
    chk("R7", "simultaneous bits", status, 16'h0101);
    sw_addr = 2'd1; #1 chk("R9", "read high ulp", {8'd0, rd_data}, 16'h0001);
    asleep = 1'b0;
    step(RST + 1);
    wake = '0; step(4);

    // R5 again: abort keeps older status
    sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    wake = 6'b001000; step(4);
    chk("R5", "abort keeps status", status, 16'h0101);
    wake = '0; step(4);

    // R6: first of two staggered lines only
    enter_sleep();
    wake = 6'b001000; step(1);
    wake = 6'b001010; step(3);
    chk("R6", "first line only", status, 16'h0008);
    asleep = 1'b0;
    step(RST + 2);
    wake = '0; step(4);
    summary();
  end

endmodule